// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns an 8-bit virtual address into a 6-bit physical address. It walks a three-level page table kept in a 64-byte physical memory, then reads the byte found at the translated address. Each table is one 4-byte page holding four one-byte entries. The virtual page number is cut into three 2-bit indices, one per level. The two low address bits are the byte offset within a page and pass straight through to the physical address.

A requester offers one address at a time with a valid/ready handshake and waits for a response. The response carries the physical address, the data byte and a fault flag. The walker owns one byte-wide read port to memory, and memory answers one cycle after each read strobe. A root frame register names the frame of the first-level table. Software can load this register only while the walker is idle.

An entry whose valid bit is clear stops the walk at once and produces a fault response. No further reads are issued after that entry.

Top module: `pt_walker`

## Requirements
- R1: Table entry addresses are formed as {table frame, 2-bit index}. The level-1 index is vaddr[7:6], the level-2 index is vaddr[5:4] and the level-3 index is vaddr[3:2]. The level-1 table frame is the root frame. Each later table frame is the frame field of the entry just read. The final data read uses address {level-3 frame, vaddr[1:0]}.
- R2: An entry holds the valid flag in bit 7 and the frame number in bits 3:0. Bits 6:4 are ignored, so an entry with those bits set translates exactly like one with them clear.
- R3: Every read is a single-cycle pulse on mem_rd with mem_addr valid in that cycle. mem_rdata is taken one cycle later. Two reads are never issued in consecutive cycles. When the request is accepted at clock edge E0, the reads occur in the cycles right after edges E0, E2, E4 and E6.
- R4: If an entry has bit 7 clear, the walk stops after that read. The response then comes two edges after that read's edge, with rsp_fault=1, rsp_data=0 and rsp_paddr=0.
- R5: A fault-free walk makes exactly four reads. Its response has rsp_fault=0, rsp_paddr = {level-3 frame, vaddr[1:0]}, and rsp_data equal to the memory byte at that address. rsp_valid rises eight edges after acceptance.
- R6: req_ready is high only when the walker is idle. It falls at acceptance and returns one cycle after the response is consumed (rsp_valid and rsp_ready both high). After reset, req_ready=1, rsp_valid=0 and mem_rd=0.
- R7: While rsp_valid is high and rsp_ready is low, rsp_valid stays high and the response fields hold their values.
- R8: root_we loads root_frame_in into the root register only when req_ready is high. A write at any other time is ignored. If a write and an acceptance happen at the same edge, the walk uses the previous root and the new value applies from the next request on. The root register resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_we | input | 1 | Root frame write strobe |
| root_frame_in | input | 4 | New root table frame |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle, request accepted this cycle if valid |
| req_vaddr | input | 8 | Virtual address to translate |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 6 | Memory byte address |
| mem_rdata | input | 8 | Memory data, one cycle after strobe |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed when high with rsp_valid |
| rsp_paddr | output | 6 | Translated physical address (0 on fault) |
| rsp_data | output | 8 | Data byte (0 on fault) |
| rsp_fault | output | 1 | Walk hit an invalid entry |

## Verification
Two functions can land on the same clock edge: loading the root frame and accepting a request. The bench provokes this by raising root_we with a new frame in the cycle where req_valid meets req_ready. It checks that every read of the walk then starting uses the old root. It also checks that the request after it walks from the new one. The bench also writes the root while a walk is in flight and while a response is stalled. It judges that the write was dropped by checking that the next walk still starts from the earlier frame.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W    = 8,
  parameter int PO_W    = 2,
  parameter int FRAME_W = 4,
  parameter int LEVELS  = 3,
  parameter int DATA_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    root_we,
  input  logic [FRAME_W-1:0]      root_frame_in,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [VA_W-1:0]         req_vaddr,
  output logic                    mem_rd,
  output logic [FRAME_W+PO_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [FRAME_W+PO_W-1:0] rsp_paddr,
  output logic [DATA_W-1:0]       rsp_data,
  output logic                    rsp_fault
);
  localparam int IDX_W     = PO_W;
  localparam int PA_W      = FRAME_W + PO_W;
  localparam int VPN_W     = VA_W - PO_W;
  localparam int LVL_W     = $clog2(LEVELS + 1);
  localparam int VALID_BIT = DATA_W - 1;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WT, S_RSP} st_t;

  st_t               st;
  logic [VA_W-1:0]   va_q;
  logic [FRAME_W-1:0] frame_q, root_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   paddr_q;
  logic [DATA_W-1:0] data_q;
  logic              fault_q;
  logic [IDX_W-1:0]  idx;
  logic [VPN_W-1:0]  vpn_sh;
  logic              accept;

  assign req_ready = (st == S_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_rd    = (st == S_RD);
  assign mem_addr  = {frame_q, idx};
  assign rsp_valid = (st == S_RSP);
  assign rsp_paddr = paddr_q;
  assign rsp_data  = data_q;
  assign rsp_fault = fault_q;

  always_comb begin
    vpn_sh = va_q[VA_W-1:PO_W] >> (IDX_W * (LEVELS - 1 - int'(lvl_q)));
    if (lvl_q == LAST_LVL) idx = va_q[PO_W-1:0];
    else                   idx = vpn_sh[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      frame_q <= '0;
      root_q  <= '0;
      lvl_q   <= '0;
      paddr_q <= '0;
      data_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      if (root_we && req_ready) root_q <= root_frame_in;
      case (st)
        S_IDLE: if (accept) begin
          va_q    <= req_vaddr;
          frame_q <= root_q;
          lvl_q   <= '0;
          st      <= S_RD;
        end
        S_RD: st <= S_WT;
        S_WT: begin
          if (lvl_q == LAST_LVL) begin
            data_q  <= mem_rdata;
            paddr_q <= {frame_q, va_q[PO_W-1:0]};
            fault_q <= 1'b0;
            st      <= S_RSP;
          end else if (!mem_rdata[VALID_BIT]) begin
            data_q  <= '0;
            paddr_q <= '0;
            fault_q <= 1'b1;
            st      <= S_RSP;
          end else begin
            frame_q <= mem_rdata[FRAME_W-1:0];
            lvl_q   <= lvl_q + 1'b1;
            st      <= S_RD;
          end
        end
        S_RSP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module pt_walker_chk #(
  parameter int VA_W   = 8,
  parameter int PA_W   = 6,
  parameter int DATA_W = 8,
  parameter int LEVELS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              mem_rd,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_fault
);
  logic [VA_W-1:0] va_seen;
  logic [3:0]      rd_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      va_seen <= '0;
      rd_cnt  <= '0;
    end else if (req_valid && req_ready) begin
      va_seen <= req_vaddr;
      rd_cnt  <= '0;
    end else if (mem_rd) begin
      rd_cnt  <= rd_cnt + 1'b1;
    end
  end

  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n) mem_rd |=> !mem_rd); // R3
  AST_FAULT_ZERO:   assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_fault) |-> (rsp_data == '0 && rsp_paddr == '0)); // R4
  AST_FULL_WALK:    assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> (rd_cnt == 4'(LEVELS + 1))); // R5
  AST_OFFSET_PASS:  assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_fault) |-> (rsp_paddr[1:0] == va_seen[1:0])); // R5
  AST_BUSY_LOW:     assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready); // R6
  AST_RSP_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready); // R6
  AST_NO_RD_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> !mem_rd); // R6
  AST_RSP_HOLD:     assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_data) && $stable(rsp_fault))); // R7
endmodule

bind pt_walker pt_walker_chk #(
  .VA_W(VA_W), .PA_W(FRAME_W + PO_W), .DATA_W(DATA_W), .LEVELS(LEVELS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_vaddr(req_vaddr), .mem_rd(mem_rd), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_data(rsp_data),
  .rsp_fault(rsp_fault)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       root_we = 1'b0;
  logic [3:0] root_frame_in = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] req_vaddr = '0;
  logic       mem_rd;
  logic [5:0] mem_addr;
  logic [7:0] mem_rdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b0;
  logic [5:0] rsp_paddr;
  logic [7:0] rsp_data;
  logic       rsp_fault;

  logic [7:0] mem [64];
  logic [3:0] root_m = 4'd0;
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

  pt_walker u0 (
    .clk(clk), .rst_n(rst_n), .root_we(root_we), .root_frame_in(root_frame_in),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic walk(input logic [7:0] va, input int stall, input bit wr_acc,
                      input logic [3:0] wr_val, input bit wr_busy);
    logic [5:0] q[$];
    logic [3:0] fr;
    logic [7:0] e;
    logic [5:0] ea;
    bit   flt;
    int   n;
    logic [5:0] xp_pa;
    logic [7:0] xp_d;
    fr = root_m;
    flt = 1'b0;
    for (int l = 0; l < 3; l++) begin
      ea = {fr, va[7-2*l -: 2]};
      q.push_back(ea);
      e = mem[ea];
      if (e[7] == 1'b0) begin flt = 1'b1; break; end
      fr = e[3:0];
    end
    if (flt) begin xp_pa = '0; xp_d = '0; end
    else begin
      xp_pa = {fr, va[1:0]};
      q.push_back(xp_pa);
      xp_d = mem[xp_pa];
    end
    n = q.size();
    chk(req_ready == 1'b1, "R6 ready before request", int'(req_ready), 1);
    req_valid = 1'b1;
    req_vaddr = va;
    root_we = wr_acc;
    root_frame_in = wr_val;
    @(negedge clk);
    if (wr_acc) root_m = wr_val;
    req_valid = 1'b0;
    root_we = 1'b0;
    for (int k = 0; k <= 2*n + stall; k++) begin
      bit xrd;
      xrd = (k % 2 == 0) && (k / 2 < n);
      chk(mem_rd == xrd, "R3 read strobe timing", int'(mem_rd), int'(xrd));
      if (xrd) chk(mem_addr == q[k/2], "R1 read address", int'(mem_addr), int'(q[k/2]));
      chk(req_ready == 1'b0, "R6 ready low while busy", int'(req_ready), 0);
      chk(rsp_valid == (k >= 2*n), flt ? "R4 response timing" : "R5 response timing",
          int'(rsp_valid), int'(k >= 2*n));
      if (k >= 2*n) begin
        chk(rsp_fault == flt, "R4 fault flag", int'(rsp_fault), int'(flt));
        chk(rsp_paddr == xp_pa, flt ? "R4 paddr" : "R5 paddr", int'(rsp_paddr), int'(xp_pa));
        chk(rsp_data == xp_d, flt ? "R4 data" : "R5 data", int'(rsp_data), int'(xp_d));
        if (k > 2*n) chk(rsp_valid == 1'b1, "R7 held under stall", int'(rsp_valid), 1);
      end
      root_we = wr_busy && (k == 3 || k == 2*n);
      root_frame_in = ~root_m;
      rsp_ready = (k == 2*n + stall);
      @(negedge clk);
    end
    root_we = 1'b0;
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R6 response consumed", int'(rsp_valid), 0);
    chk(req_ready == 1'b1, "R6 ready after consume", int'(req_ready), 1);
  endtask

  task automatic root_load(input logic [3:0] v);
    root_we = 1'b1;
    root_frame_in = v;
    @(negedge clk);
    root_we = 1'b0;
    root_m = v;
    chk(req_ready == 1'b1, "R8 idle load", int'(req_ready), 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) mem[a] = 8'(a * 7 + 3);
    mem[4]  = 8'h82; mem[5]  = 8'h00; mem[6]  = 8'hF3; mem[7]  = 8'h82;
    mem[8]  = 8'h84; mem[9]  = 8'h85; mem[10] = 8'h04; mem[11] = 8'h84;
    mem[12] = 8'h86; mem[13] = 8'h86; mem[14] = 8'h86; mem[15] = 8'h86;
    mem[16] = 8'h8A; mem[17] = 8'h8B; mem[18] = 8'h0C; mem[19] = 8'h8F;
    mem[20] = 8'h8D; mem[21] = 8'h8D; mem[22] = 8'h8D; mem[23] = 8'h8D;
    mem[24] = 8'hFE; mem[25] = 8'h89; mem[26] = 8'h89; mem[27] = 8'h89;
    mem[28] = 8'h82; mem[29] = 8'h82; mem[30] = 8'h82; mem[31] = 8'h00;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R6 reset ready", int'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R6 reset rsp_valid", int'(rsp_valid), 0);
    chk(mem_rd == 1'b0, "R6 reset mem_rd", int'(mem_rd), 0);

    walk(8'h00, 0, 1'b0, 4'd0, 1'b0);   // R8 reset root 0: level-1 fault
    root_load(4'd1);
    walk(8'h00, 0, 1'b0, 4'd0, 1'b0);   // R1 R5 full walk
    walk(8'h47, 0, 1'b0, 4'd0, 1'b0);   // R4 level-1 fault
    walk(8'h21, 1, 1'b0, 4'd0, 1'b0);   // R4 level-2 fault
    walk(8'h0B, 0, 1'b0, 4'd0, 1'b0);   // R4 level-3 fault
    walk(8'h82, 0, 1'b0, 4'd0, 1'b0);   // R2 reserved bits set
    walk(8'hFF, 3, 1'b0, 4'd0, 1'b1);   // R7 stall, R8 busy write ignored
    walk(8'h0E, 0, 1'b0, 4'd0, 1'b0);   // R8 root still 1
    walk(8'h00, 2, 1'b1, 4'd7, 1'b0);   // R8 same-edge write: old root used
    walk(8'hC0, 0, 1'b0, 4'd0, 1'b0);   // R8 new root: level-1 fault
    walk(8'h13, 0, 1'b0, 4'd0, 1'b0);   // R1 walk from root 7
    root_load(4'd1);
    walk(8'h0F, 0, 1'b0, 4'd0, 1'b0);   // R5
    walk(8'h52, 2, 1'b0, 4'd0, 1'b1);   // R8 write during stalled fault response

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule